// File: doc/BRIEF.md
# Interrupt Router Core

This block gathers level-sensitive interrupt request lines from a configurable number of peripheral sources and presents one interrupt line to each of a few processor contexts. Each source has a programmable priority. Each context has its own set of enable bits and its own priority threshold. A context's line is raised while at least one source is pending, enabled for that context, and above that context's threshold.

Software drives the block through a 32-bit word-addressed read/write port. When it reads a context's claim register it receives the identifier of the best pending source, and that read also clears the source's pending bit. When it has serviced the source, it writes the same identifier back to the same register. That completion re-arms the source's request gateway, so a line that is still high raises a new request.

Sources are numbered from 1. Identifier 0 never exists and means "nothing to claim". Register placement is fixed by the address map given in the requirements.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable word, threshold and pending bit is zero, every context output is low, and every claim read returns 0.
- R2: Source n (1 to NUM_SRC) has a priority register at byte address 4·n, holding the low PRIO_W bits (default 3) of the written word. Address 0 and addresses of identifiers above NUM_SRC read 0 and ignore writes.
- R3: Context c has enable words at byte address 0x2000 + 0x80·c + 4·w. Bit b of word w enables source 32·w + b. The bit for identifier 0, bits above NUM_SRC, and words past the last one read 0.
- R4: A context's output is high exactly when some source is pending, enabled for that context, and has a priority strictly greater than the context's threshold. A priority of 0 therefore never raises an output.
- R5: A read of the claim register of context c (byte address 0x200004 + 0x1000·c) returns the qualifying source with the highest priority. Among equal priorities the lower identifier wins. The read returns 0 when no source qualifies.
- R6: A claim read that returns a nonzero identifier clears that source's pending bit at the same clock edge, so the output drops if nothing else qualifies.
- R7: Once a source's request is latched, its line is ignored until a completion for it arrives. If the line is still high after the completion, the request is latched again one clock later.
- R8: A completion write naming a source that is not enabled for the context written to has no effect.
- R9: The threshold of context c sits at byte address 0x200000 + 0x1000·c. When it is lowered below a pending source's priority, the output rises right after the write, with no other access needed.
- R10: Thresholds keep only the low 3 bits of the written word. Reads of any unmapped address return 0.
- R11: Contexts are independent: a source enabled only for one context never raises, and is never claimed from, another context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSrc | input | NUM_SRC | Level request lines; bit n-1 belongs to source n |
| busWe | input | 1 | Write strobe, takes effect at the clock edge |
| busRe | input | 1 | Read strobe; a claim read clears pending at the clock edge |
| busAddr | input | ADDR_W | Byte address of the accessed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address and state |
| irqOut | output | NUM_CTX | Per-context interrupt request |

## Verification
Suppose the pending or gateway-busy state of a source goes wrong. The bench sees it within one or two cycles: an output that should be low stays high, a second claim returns the same identifier, or a line that is held high either re-raises the output with no completion or fails to re-raise it one cycle after the completion. A wrong arbitration or threshold compare shows directly on the next claim read or on the output. The bench sweeps every priority against every threshold and runs fixed multi-source claim orders to catch this. Decoding faults show up as the wrong register answering on readback sweeps across the priority and enable regions.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CTX_IDX_W = 8;
  localparam int SLOT_W    = 10;
  localparam int DATA_W    = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } regSel_e;

  // Strobes from the address decoder to the register/arbitration datapath
  typedef struct packed {
    logic                 wr;
    logic                 rd;
    regSel_e              sel;
    logic [CTX_IDX_W-1:0] ctx;
    logic [SLOT_W-1:0]    idx;
    logic [DATA_W-1:0]    data;
  } busStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output busStrobe_t        strb
);
  localparam int NWORDS = (NUM_SRC + 32) / 32;
  localparam logic [ADDR_W-1:0] PRIO_LIMIT = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] EN_BASE    = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] EN_LIMIT   = ADDR_W'(32'h2000 + 32'h80 * NUM_CTX);
  localparam logic [ADDR_W-1:0] CTX_BASE   = ADDR_W'(32'h200000);
  localparam logic [ADDR_W-1:0] CTX_LIMIT  = ADDR_W'(32'h200000 + 32'h1000 * NUM_CTX);

  logic [ADDR_W-1:0] enOff;
  logic [ADDR_W-1:0] ctxOff;

  assign enOff  = busAddr - EN_BASE;
  assign ctxOff = busAddr - CTX_BASE;

  always_comb begin
    strb      = '0;
    strb.wr   = busWe;
    strb.rd   = busRe;
    strb.data = busWdata;
    strb.sel  = SEL_NONE;
    if (busAddr < PRIO_LIMIT) begin
      strb.idx = busAddr[11:2];
      if (busAddr[11:2] != '0 && busAddr[11:2] <= SLOT_W'(NUM_SRC))
        strb.sel = SEL_PRIO;
    end else if (busAddr >= EN_BASE && busAddr < EN_LIMIT) begin
      strb.ctx = CTX_IDX_W'(enOff >> 7);
      strb.idx = SLOT_W'(busAddr[6:2]);
      if ({1'b0, busAddr[6:2]} < 6'(NWORDS))
        strb.sel = SEL_EN;
    end else if (busAddr >= CTX_BASE && busAddr < CTX_LIMIT) begin
      strb.ctx = CTX_IDX_W'(ctxOff >> 12);
      if (busAddr[11:0] == 12'h000)
        strb.sel = SEL_THR;
      else if (busAddr[11:0] == 12'h004)
        strb.sel = SEL_CLAIM;
    end
  end
endmodule

// File: rtl/irq_router_arbiter.sv
module irq_router_arbiter #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC:0]  cand,
  input  logic [PRIO_W-1:0] prio [NUM_SRC+1],
  input  logic [PRIO_W-1:0] thr,
  output logic [ID_W-1:0]   winId
);
  logic [PRIO_W-1:0] bestPri;

  // Ascending scan with a strict compare: the threshold seeds the running
  // best, so only priorities above it win, and an equal priority found later
  // never displaces a lower identifier.
  always_comb begin
    winId   = '0;
    bestPri = thr;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (cand[i] && prio[i] > bestPri) begin
        bestPri = prio[i];
        winId   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_router_datapath.sv
module irq_router_datapath
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  busStrobe_t         strb,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CTX-1:0] irqOut,
  output logic [NUM_SRC:0]   pendVec,
  output logic [NUM_SRC:0]   busyVec
);
  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int THR_W = 3;

  logic [PRIO_W-1:0] prioReg [NUM_SRC+1];
  logic [NUM_SRC:0]  enReg   [NUM_CTX];
  logic [PRIO_W-1:0] thrReg  [NUM_CTX];
  logic [NUM_SRC:0]  pendReg;
  logic [NUM_SRC:0]  busyReg;
  logic [NUM_SRC:0]  lineVec;
  logic [ID_W-1:0]   winId   [NUM_CTX];

  logic [CTX_W-1:0] ctxSel;
  logic [ID_W-1:0]  slotId;
  logic [ID_W-1:0]  doneId;
  logic [ID_W-1:0]  claimId;
  logic             doneOk;
  logic             claimHit;
  logic             unusedBits;

  assign lineVec    = {irqSrc, 1'b0};
  assign ctxSel     = strb.ctx[CTX_W-1:0];
  assign slotId     = strb.idx[ID_W-1:0];
  assign doneId     = strb.data[ID_W-1:0];
  assign claimId    = winId[ctxSel];
  assign unusedBits = ^{strb.ctx, strb.idx, strb.data};

  assign doneOk   = strb.wr && strb.sel == SEL_CLAIM && strb.data != '0 &&
                    strb.data <= DATA_W'(NUM_SRC) && enReg[ctxSel][doneId];
  assign claimHit = strb.rd && strb.sel == SEL_CLAIM && claimId != '0;

  genvar c;
  generate
    for (c = 0; c < NUM_CTX; c++) begin : g_ctx
      irq_router_arbiter #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
      ) u_arb (
        .cand (pendReg & enReg[c]),
        .prio (prioReg),
        .thr  (thrReg[c]),
        .winId(winId[c])
      );
      assign irqOut[c] = winId[c] != '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= NUM_SRC; i++) prioReg[i] <= '0;
      for (int k = 0; k < NUM_CTX; k++) begin
        enReg[k]  <= '0;
        thrReg[k] <= '0;
      end
      pendReg <= '0;
      busyReg <= '0;
    end else begin
      if (strb.wr) begin
        case (strb.sel)
          SEL_PRIO: prioReg[slotId] <= strb.data[PRIO_W-1:0];
          SEL_EN: begin
            for (int i = 1; i <= NUM_SRC; i++)
              if (i / 32 == int'(strb.idx)) enReg[ctxSel][i] <= strb.data[i % 32];
          end
          SEL_THR: thrReg[ctxSel] <= PRIO_W'(strb.data[THR_W-1:0]);
          default: ;
        endcase
      end
      // Completion re-arms the gateway; the gateway set below wins a tie.
      if (doneOk) busyReg[doneId] <= 1'b0;
      if (claimHit) pendReg[claimId] <= 1'b0;
      for (int i = 1; i <= NUM_SRC; i++) begin
        if (lineVec[i] && !busyReg[i]) begin
          pendReg[i] <= 1'b1;
          busyReg[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strb.sel)
      SEL_PRIO: rdData = DATA_W'(prioReg[slotId]);
      SEL_EN: begin
        for (int i = 1; i <= NUM_SRC; i++)
          if (i / 32 == int'(strb.idx)) rdData[i % 32] = enReg[ctxSel][i];
      end
      SEL_THR:   rdData = DATA_W'(thrReg[ctxSel]);
      SEL_CLAIM: rdData = DATA_W'(claimId);
      default: ;
    endcase
  end

  assign pendVec = pendReg;
  assign busyVec = busyReg;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CTX-1:0] irqOut
);
  busStrobe_t       strb;
  logic [NUM_SRC:0] pendVec;
  logic [NUM_SRC:0] busyVec;

  irq_router_ctrl #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strb    (strb)
  );

  irq_router_datapath #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX),
    .PRIO_W (PRIO_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqSrc (irqSrc),
    .strb   (strb),
    .rdData (busRdata),
    .irqOut (irqOut),
    .pendVec(pendVec),
    .busyVec(busyVec)
  );
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqSrc,
  input logic               busRe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdata,
  input logic [NUM_CTX-1:0] irqOut,
  input logic [NUM_SRC:0]   pendState,
  input logic [NUM_SRC:0]   busyState
);
  localparam logic [ADDR_W-1:0] CLAIM0 = ADDR_W'(32'h200004);

  logic claimRd0;
  assign claimRd0 = busRe && busAddr == CLAIM0;

  p_id0_never_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pendState[0]) else $error("identifier 0 became pending");

  p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> (pendState != '0)) else $error("output high with nothing pending");

  p_claim_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd0 && !irqOut[0]) |-> (busRdata == '0)) else $error("idle claim returned nonzero");

  p_claim_live_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd0 && irqOut[0]) |-> (busRdata != '0)) else $error("live claim returned zero");

  p_pending_implies_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendState & ~busyState) == '0) else $error("pending source with idle gateway");

  p_pend_rise_needs_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendState & ~$past(pendState) & ~{$past(irqSrc), 1'b0}) == '0)
    else $error("pending bit set without a request line");
endmodule

bind irq_router irq_router_checker #(
  .NUM_SRC(NUM_SRC),
  .NUM_CTX(NUM_CTX),
  .ADDR_W (ADDR_W)
) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .irqSrc   (irqSrc),
  .busRe    (busRe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .pendState(pendVec),
  .busyState(busyVec)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NSRC = 40;
  localparam int NCTX = 2;
  localparam int AW   = 26;

  logic            clk   = 1'b0;
  logic            rstN  = 1'b0;
  logic [NSRC-1:0] src   = '0;
  logic            we    = 1'b0;
  logic            re    = 1'b0;
  logic [AW-1:0]   addr  = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCTX-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_router #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .irqSrc(src), .busWe(we), .busRe(re),
    .busAddr(addr), .busWdata(wdata), .busRdata(rdata), .irqOut(irq)
  );

  function automatic logic [AW-1:0] pa(int id);
    return AW'(4 * id);
  endfunction
  function automatic logic [AW-1:0] ea(int c, int w);
    return AW'(32'h2000 + 32'h80 * c + 4 * w);
  endfunction
  function automatic logic [AW-1:0] ta(int c);
    return AW'(32'h200000 + 32'h1000 * c);
  endfunction
  function automatic logic [AW-1:0] ca(int c);
    return AW'(32'h200004 + 32'h1000 * c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; src = '0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic pulse(input logic [NSRC-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    src = '0;
  endtask

  task automatic irqIs(input string req, input int c, input logic exp);
    #1 chk(req, 32'(irq[c]), 32'(exp));
  endtask

  task automatic resetState(input string req);
    logic [31:0] v;
    #1 chk(req, 32'(irq), 32'h0);
    rd(pa(7), v);     chk(req, v, 32'h0);
    rd(ea(0, 0), v);  chk(req, v, 32'h0);
    rd(ea(1, 1), v);  chk(req, v, 32'h0);
    rd(ta(0), v);     chk(req, v, 32'h0);
    rd(ca(1), v);     chk(req, v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    doReset();
    resetState("R1");

    // R2: priority sweep across valid ids and both out-of-range ends
    for (int id = 0; id <= NSRC + 2; id++)
      wr(pa(id), 32'hFFFF_FF00 | 32'(id * 3));
    for (int id = 0; id <= NSRC + 2; id++) begin
      rd(pa(id), v);
      chk("R2", v, (id >= 1 && id <= NSRC) ? 32'((id * 3) % 8) : 32'h0);
    end

    // R3: enable bit mapping
    wr(ea(0, 0), 32'hFFFF_FFFF);
    wr(ea(0, 1), 32'hFFFF_FFFF);
    wr(ea(1, 1), 32'h0000_0005);
    rd(ea(0, 0), v); chk("R3", v, 32'hFFFF_FFFE);
    rd(ea(0, 1), v); chk("R3", v, 32'h0000_01FF);
    rd(ea(1, 0), v); chk("R3", v, 32'h0);
    rd(ea(1, 1), v); chk("R3", v, 32'h5);
    rd(ea(0, 2), v); chk("R3", v, 32'h0);

    // R1 again: reset must clear programmed state
    doReset();
    resetState("R1");

    // R4: every priority against every threshold on one pending source
    wr(ea(0, 0), 32'h1 << 5);
    pulse(NSRC'(1) << 4);
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 8; t++) begin
        wr(pa(5), 32'(p));
        wr(ta(0), 32'(t));
        irqIs("R4", 0, p > t);
      end
    end
    irqIs("R11", 1, 1'b0);

    // R5/R6: claim order with ties and a source in the second word
    doReset();
    wr(pa(3), 2); wr(pa(7), 5); wr(pa(9), 5); wr(pa(33), 6);
    wr(ea(0, 0), (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9));
    wr(ea(0, 1), 32'h1 << 1);
    pulse((NSRC'(1) << 2) | (NSRC'(1) << 6) | (NSRC'(1) << 8) | (NSRC'(1) << 32));
    irqIs("R4", 0, 1'b1);
    rd(ca(0), v); chk("R5", v, 33);
    rd(ca(0), v); chk("R5", v, 7);
    rd(ca(0), v); chk("R5", v, 9);
    rd(ca(0), v); chk("R5", v, 3);
    rd(ca(0), v); chk("R5", v, 0);
    irqIs("R6", 0, 1'b0);
    wr(ca(0), 33); wr(ca(0), 7); wr(ca(0), 9); wr(ca(0), 3);
    idle(2);
    irqIs("R7", 0, 1'b0);

    // R7: held line is ignored in flight and re-latched after completion
    wr(pa(12), 1);
    wr(ea(0, 0), 32'h1 << 12);
    @(negedge clk); src[11] = 1'b1;
    idle(1);
    irqIs("R7", 0, 1'b1);
    rd(ca(0), v); chk("R5", v, 12);
    irqIs("R6", 0, 1'b0);
    idle(3);
    irqIs("R7", 0, 1'b0);
    wr(ca(0), 12);
    idle(1);
    irqIs("R7", 0, 1'b1);
    src[11] = 1'b0;
    rd(ca(0), v); chk("R7", v, 12);
    wr(ca(0), 12);
    idle(2);
    irqIs("R7", 0, 1'b0);

    // R8/R11: completion to the wrong context and context isolation
    wr(pa(20), 4);
    wr(ea(0, 0), 0);
    wr(ea(1, 0), 32'h1 << 20);
    @(negedge clk); src[19] = 1'b1;
    idle(1);
    irqIs("R11", 1, 1'b1);
    irqIs("R11", 0, 1'b0);
    rd(ca(0), v); chk("R11", v, 0);
    rd(ca(1), v); chk("R5", v, 20);
    wr(ca(0), 20);
    idle(2);
    irqIs("R8", 1, 1'b0);
    wr(ca(1), 20);
    idle(1);
    irqIs("R8", 1, 1'b1);
    src[19] = 1'b0;
    rd(ca(1), v); chk("R6", v, 20);
    wr(ca(1), 20);

    // R9: lowering the threshold releases a waiting source
    wr(ta(0), 5);
    wr(pa(15), 3);
    wr(ea(0, 0), 32'h1 << 15);
    pulse(NSRC'(1) << 14);
    irqIs("R9", 0, 1'b0);
    wr(ta(0), 2);
    irqIs("R9", 0, 1'b1);
    rd(ca(0), v); chk("R9", v, 15);

    // R10: threshold width and unmapped addresses
    wr(ta(1), 32'hFF);
    rd(ta(1), v); chk("R10", v, 7);
    wr(ta(1), 32'h0A);
    rd(ta(1), v); chk("R10", v, 2);
    rd(AW'(32'h1FFC), v);            chk("R10", v, 0);
    rd(ea(2, 0), v);                 chk("R10", v, 0);
    rd(AW'(32'h3000), v);            chk("R10", v, 0);
    rd(AW'(32'h200008), v);          chk("R10", v, 0);
    rd(ta(2), v);                    chk("R10", v, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule